// File: doc/BRIEF.md
# Periodic Seconds Drift Trimmer

This unit sits between a seconds prescaler and a seconds counter and applies a fixed whole-second correction at a programmed interval. It counts incoming second ticks. Each time the programmed period of match+1 ticks completes, it either removes one tick from the output stream or adds one extra tick. The period then starts again. Over time this shifts the downstream clock by one second per period, so the rate changes by roughly 1e9/(match+1) parts per billion. Converting a wanted ppb figure into a period is left to software.

Setup uses a single 32-bit configuration word, which is loaded whenever the write strobe is high. The input is a one-cycle tick pulse from the prescaler. The output is a one-cycle corrected tick, delayed by one clock. Input ticks must be at least two clock cycles apart. This leaves room for the added pulse that follows a normal one.

Top module: `sec_trim_unit`

## Requirements
- R1: When `cfg_wr` is high, the configuration word on `cfg_data` is loaded. Bits 18:0 give the period count `match`, bits 20:19 give the mode, and bit 23 is the enable flag. All other bits have no effect on behaviour.
- R2: When no correction applies, each input tick produces exactly one output tick, one clock cycle after the input tick.
- R3: While the enable flag is 0, every tick passes through unchanged, whatever the mode and period are.
- R4: Mode codes 0 and 1 apply no correction, even with the enable flag set.
- R5: Mode code 2 (drop) removes the output tick for the (match+1)-th counted input tick of each period. All other ticks pass.
- R6: Mode code 3 (add) passes the (match+1)-th counted input tick normally. It then emits one extra output tick in the following cycle, which is two cycles after the input tick.
- R7: A configuration write restarts the period count from zero. A tick that arrives in the same cycle as a write passes unchanged and is not counted.
- R8: With `match` equal to 0, every counted tick is corrected. In drop mode no ticks reach the output, and in add mode every tick is doubled.
- R9: After reset, `tick_out` is low and the loaded configuration is all zero, so ticks pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for the configuration word |
| cfg_data | input | 32 | Configuration word (enable, mode, period) |
| tick_in | input | 1 | Raw seconds tick, one cycle wide |
| tick_out | output | 1 | Corrected seconds tick, one cycle wide |

## Verification
A period counter in the wrong state shows up at the port as a correction in the wrong place. A dropped or added pulse appears on a different input tick than the model predicts, and this is visible within one period of the fault. If the counter fails to restart after a write, the first correction after reconfiguration comes early or late. A broken mode decode shows immediately, as a missing or spurious pulse on the first corrected tick. The scoreboard expects every output pulse in an exact cycle, so a shift of even one clock in the added pulse is reported.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    // Correction mode codes held in the configuration word
    typedef enum logic [1:0] {
        TRIM_NONE0 = 2'd0,
        TRIM_NONE1 = 2'd1,
        TRIM_DROP  = 2'd2,
        TRIM_ADD   = 2'd3
    } trim_mode_e;

    // A correction applies only when enabled and the mode is drop or add
    function automatic logic trim_applies(input logic enable, input trim_mode_e mode);
        return enable && (mode == TRIM_DROP || mode == TRIM_ADD);
    endfunction

endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
    import sec_trim_pkg::*;
#(
    parameter int MATCH_W = 19,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [REG_W-1:0]   cfg_data,
    output logic               active,
    output logic               drop_en,
    output logic               add_en,
    output logic [MATCH_W-1:0] match
);
    localparam int MODE_LSB = MATCH_W;
    localparam int EN_BIT   = MATCH_W + 4;
    localparam logic [REG_W-1:0] USED_MASK =
        ({{(REG_W-1){1'b0}}, 1'b1} << EN_BIT) |
        ({{(REG_W-2){1'b0}}, 2'b11} << MODE_LSB) |
        {{(REG_W-MATCH_W){1'b0}}, {MATCH_W{1'b1}}};

    typedef struct packed {
        logic               enable;
        trim_mode_e         mode;
        logic [MATCH_W-1:0] period;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic [REG_W-1:0] unused_bits;

    assign unused_bits = cfg_data & ~USED_MASK;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.enable = cfg_data[EN_BIT];
            cfg_d.mode   = trim_mode_e'(cfg_data[MODE_LSB+1:MODE_LSB]);
            cfg_d.period = cfg_data[MATCH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign active  = trim_applies(cfg_q.enable, cfg_q.mode);
    assign drop_en = active && (cfg_q.mode == TRIM_DROP);
    assign add_en  = active && (cfg_q.mode == TRIM_ADD);
    assign match   = cfg_q.period;

    // R1: a write lands the period field in the register on the next edge
    p_period_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (match == $past(cfg_data[MATCH_W-1:0])));

    // R4: low mode codes never enable a correction
    p_low_mode_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_data[MODE_LSB+1]) |=> !active);

endmodule

// File: rtl/sec_trim_period.sv
module sec_trim_period #(
    parameter int MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_in,
    input  logic               cfg_wr,
    input  logic               active,
    input  logic [MATCH_W-1:0] match,
    output logic               fire
);
    typedef struct packed {
        logic [MATCH_W-1:0] cnt;
    } ctr_t;

    ctr_t st_q, st_d;
    logic last_of_period;

    assign last_of_period = (st_q.cnt == match);
    assign fire = tick_in && active && !cfg_wr && last_of_period;

    always_comb begin
        st_d = st_q;
        if (cfg_wr || !active) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            if (last_of_period) st_d.cnt = '0;
            else                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: any configuration write restarts the period
    p_write_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (st_q.cnt == '0));

    // R5: the count never passes the programmed period while correcting
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (st_q.cnt <= match));

endmodule

// File: rtl/sec_trim_pulse.sv
module sec_trim_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic fire,
    input  logic drop_en,
    input  logic add_en,
    output logic tick_out
);
    typedef struct packed {
        logic out;
        logic extra;
    } pls_t;

    pls_t st_q, st_d;

    always_comb begin
        st_d.out   = (tick_in && !(fire && drop_en)) || st_q.extra;
        st_d.extra = tick_in && fire && add_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_out = st_q.out;

    // R2: an uncorrected tick appears one cycle later
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !fire) |=> tick_out);

    // R5: a dropped tick leaves the output low
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && fire && drop_en) |=> !tick_out);

    // R6: an added tick shows two cycles after the input tick
    p_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && fire && add_en) |-> ##2 tick_out);

    // R6: input ticks must leave a free cycle for the added pulse
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_in |=> !tick_in);

endmodule

// File: rtl/sec_trim_unit.sv
module sec_trim_unit #(
    parameter int MATCH_W = 19,
    parameter int REG_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_data,
    input  logic             tick_in,
    output logic             tick_out
);
    logic               active;
    logic               drop_en;
    logic               add_en;
    logic               fire;
    logic [MATCH_W-1:0] match;

    sec_trim_cfg #(.MATCH_W(MATCH_W), .REG_W(REG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .active   (active),
        .drop_en  (drop_en),
        .add_en   (add_en),
        .match    (match)
    );

    sec_trim_period #(.MATCH_W(MATCH_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_in),
        .cfg_wr  (cfg_wr),
        .active  (active),
        .match   (match),
        .fire    (fire)
    );

    sec_trim_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_in),
        .fire     (fire),
        .drop_en  (drop_en),
        .add_en   (add_en),
        .tick_out (tick_out)
    );

    // R9: output is quiet straight after reset
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tick_out);

endmodule

// File: tb/sec_trim_unit_test.sv
module sec_trim_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        tick_in = 1'b0;
    logic        tick_out;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    string phase = "R9";
    exp_t q[$];

    // reference model of the configuration and period count
    bit          m_en = 0;
    logic [1:0]  m_mode = 2'd0;
    int          m_match = 0;
    int          m_cnt = 0;

    sec_trim_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .tick_in  (tick_in),
        .tick_out (tick_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] enc(bit en, logic [1:0] mode, int match, logic [31:0] junk);
        return junk | (32'(en) << 23) | (32'(mode) << 19) | (32'(match) & 32'h7FFFF);
    endfunction

    task automatic push(int at, string req);
        exp_t e;
        e.at = at;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic send_tick(string req);
        bit act;
        @(negedge clk);
        tick_in = 1'b1;
        act = m_en && m_mode[1];
        if (act && m_cnt == m_match) begin
            m_cnt = 0;
            if (m_mode == 2'd3) begin
                push(cyc + 1, req);
                push(cyc + 2, req);
            end
        end else begin
            if (act) m_cnt++;
            push(cyc + 1, req);
        end
        @(negedge clk);
        tick_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_cfg(logic [31:0] w, bit with_tick, string req);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = w;
        if (with_tick) begin
            tick_in = 1'b1;
            push(cyc + 1, req);
        end
        m_en = w[23];
        m_mode = w[20:19];
        m_match = int'(w[18:0]);
        m_cnt = 0;
        @(negedge clk);
        cfg_wr = 1'b0;
        tick_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(string req);
        repeat (4) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: pending expected pulses actual=%0d expected=0", req, q.size());
            q.delete();
        end
    endtask

    // monitor: compares output pulses against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].at == cyc) begin
                n_chk++;
                if (tick_out !== 1'b1) begin
                    n_fail++;
                    $display("FAIL %s: tick_out at cycle %0d actual=%b expected=1", q[0].req, cyc, tick_out);
                end
                void'(q.pop_front());
            end else if (tick_out !== 1'b0) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s: spurious tick_out at cycle %0d actual=%b expected=0", phase, cyc, tick_out);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (tick_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: tick_out after reset actual=%b expected=0", tick_out);
        end
        // R9: cleared configuration passes ticks
        for (int i = 0; i < 3; i++) send_tick("R9");
        drain("R9");

        // R3: enable flag low blocks any correction
        phase = "R3";
        write_cfg(enc(0, 2'd3, 0, 32'h0), 0, "R3");
        for (int i = 0; i < 3; i++) send_tick("R3");
        write_cfg(enc(0, 2'd2, 0, 32'h0), 0, "R3");
        for (int i = 0; i < 3; i++) send_tick("R3");
        drain("R3");

        // R4: low mode codes do nothing
        phase = "R4";
        write_cfg(enc(1, 2'd0, 0, 32'h0), 0, "R4");
        for (int i = 0; i < 3; i++) send_tick("R4");
        write_cfg(enc(1, 2'd1, 0, 32'h0), 0, "R4");
        for (int i = 0; i < 3; i++) send_tick("R4");
        drain("R4");

        // R5: drop every fourth tick
        phase = "R5";
        write_cfg(enc(1, 2'd2, 3, 32'h0), 0, "R5");
        for (int i = 0; i < 10; i++) send_tick("R5");
        drain("R5");

        // R6 and R1: add after every third tick, unused bits set
        phase = "R1";
        write_cfg(enc(1, 2'd3, 2, 32'hFF60_0000), 0, "R1");
        for (int i = 0; i < 7; i++) send_tick("R6");
        drain("R6");

        // R8: period of one tick
        phase = "R8";
        write_cfg(enc(1, 2'd3, 0, 32'h0), 0, "R8");
        for (int i = 0; i < 3; i++) send_tick("R8");
        write_cfg(enc(1, 2'd2, 0, 32'h0), 0, "R8");
        for (int i = 0; i < 3; i++) send_tick("R8");
        drain("R8");

        // R7: rewrite mid-period with a tick in the write cycle
        phase = "R7";
        write_cfg(enc(1, 2'd2, 3, 32'h0), 0, "R7");
        for (int i = 0; i < 2; i++) send_tick("R7");
        write_cfg(enc(1, 2'd2, 3, 32'h0), 1, "R7");
        for (int i = 0; i < 5; i++) send_tick("R7");
        drain("R7");

        // R2: plain pass-through after disabling
        phase = "R2";
        write_cfg(enc(0, 2'd0, 5, 32'h0), 0, "R2");
        for (int i = 0; i < 4; i++) send_tick("R2");
        drain("R2");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule